// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Bus Bridge

This block connects an external 8-bit host bus, which runs with no relation to the core clock, to a synchronous register port inside the chip. A static mode input chooses one of two host conventions. In mode 0 an address-latch pulse captures the address, and three active-low pins act as chip select, read strobe and write strobe. The handshake is an active-high ready. In mode 1 the address-latch input is held high and is ignored. The three pins then act as an active-low address strobe, a read/write direction line and an active-low data strobe, and the handshake is an active-low transfer acknowledge.

All host inputs go through a two-stage synchronizer before the block decodes them. Address and data travel through the same pipeline as the strobes, so all of them stay aligned. A small state machine turns each host cycle into exactly one single-clock read or write pulse on the internal port. It waits for read data or for the write to be issued, raises the handshake, and holds it until the host releases the strobes. The bidirectional data bus is split into an input, an output and an output-enable signal. The register contents sit outside this block.

Top module: `hbi_host_bridge`

## Requirements
- R1: `mode_sel` = 0 selects the separate-strobe convention and `mode_sel` = 1 selects the address/data-strobe convention; with every strobe pin high, neither mode starts a cycle.
- R2: In mode 0 the internal address is the value on `addr_in` just before `ale` falls from 1 to 0; later changes on `addr_in` while `ale` is low do not affect it.
- R3: In mode 0, `strb_n` low together with exactly one of `rdwr` (read strobe, active low) or `ds_n` (write strobe, active low) low starts a cycle; with `strb_n` high, no cycle starts.
- R4: In mode 1, a cycle starts only once both `strb_n` and `ds_n` are low; `rdwr` = 1 means read and 0 means write; the address is taken from `addr_in` at cycle start.
- R5: Each host cycle produces exactly one single-clock pulse on `reg_rd` or `reg_wr`, never both, even if the strobes are held for many clocks.
- R6: `data_oe` is 1 only while a read is selected (mode 0: `strb_n` and `rdwr` low; mode 1: `strb_n` low and `rdwr` high). Once the handshake is active, `data_out` carries the read data.
- R7: The handshake `ack_out` is active-high in mode 0 (idle 0) and active-low in mode 1 (idle 1).
- R8: The handshake turns active only after the write pulse has been issued, or after `reg_rvalid` has returned read data. It stays active while the strobes are held, and it returns to idle after the host releases them.
- R9: Write data is captured when the cycle starts and held on `reg_wdata`; changes on `data_in` afterwards do not alter it.
- R10: After reset, `reg_rd`, `reg_wr` and `data_oe` are 0 and `ack_out` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Static bus convention select |
| ale | input | 1 | Address latch enable (mode 0), held high in mode 1 |
| addr_in | input | 10 | Host address bus |
| data_in | input | 8 | Host data bus, inbound half |
| data_out | output | 8 | Host data bus, outbound half |
| data_oe | output | 1 | Drive enable for the host data bus |
| strb_n | input | 1 | Chip select (mode 0) or address strobe (mode 1), active low |
| rdwr | input | 1 | Read strobe, active low (mode 0), or direction, 1 = read (mode 1) |
| ds_n | input | 1 | Write strobe (mode 0) or data strobe (mode 1), active low |
| ack_out | output | 1 | Ready (mode 0, active high) or transfer acknowledge (mode 1, active low) |
| reg_addr | output | 10 | Internal register address |
| reg_wdata | output | 8 | Internal write data |
| reg_wr | output | 1 | Single-clock internal write pulse |
| reg_rd | output | 1 | Single-clock internal read pulse |
| reg_rdata | input | 8 | Internal read data |
| reg_rvalid | input | 1 | Read data valid, one clock |

## Verification
The bench holds strobes for many clocks to catch a bridge that issues a second pulse while it waits for release. A bridge that re-fires would double-count writes. In mode 0 it changes the address after the latch pulse falls, which exposes a bridge that samples the address at strobe time. In mode 1 it lowers only the address strobe first, so a bridge that starts on one strobe would write early. It also disturbs the data bus after the write, checks the handshake polarity per mode, and checks that the data bus is released as soon as the read strobe rises.

// File: rtl/hbi_pkg.sv
// Shared types for the host bus bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package hbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ACK   = 2'd3
    } hbi_state_t;

    localparam logic MODE_SPLIT  = 1'b0;
    localparam logic MODE_STROBE = 1'b1;

endpackage

// File: rtl/hbi_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Every bit passes through STAGES flops, so bits that were sampled together
// leave together. Assumes the host holds a value steady for longer than
// STAGES clocks when it matters (address and data around a strobe).
module hbi_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: sample the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later flops: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hbi_decode.sv
// Maps the three synchronized control pins onto "cycle active" and
// "cycle is a read" according to the static mode input.
// Mode 0: strb = chip select, rdwr = read strobe, ds = write strobe (all
//         active low); a cycle needs select plus exactly one strobe.
// Mode 1: strb = address strobe, ds = data strobe (active low),
//         rdwr = direction (1 = read); a cycle needs both strobes low.
// Assumes mode_sel is static while the bus is in use.
module hbi_decode
    import hbi_pkg::*;
(
    input  logic mode_sel,
    input  logic strb_n_s,
    input  logic rdwr_s,
    input  logic ds_n_s,
    output logic cyc_active,
    output logic cyc_read
);

    // Purpose: decode the pin meanings for the selected convention.
    always_comb begin
        if (mode_sel == MODE_STROBE) begin
            cyc_active = !strb_n_s && !ds_n_s;
            cyc_read   = rdwr_s;
        end else begin
            cyc_active = !strb_n_s && (rdwr_s ^ ds_n_s);
            cyc_read   = !rdwr_s;
        end
    end

endmodule

// File: rtl/hbi_ctrl.sv
// Cycle controller: turns one decoded host cycle into one internal pulse,
// holds address, write data and read data, and drives the raw handshake.
// Assumes all inputs are already synchronized to clk and that the internal
// port answers each read pulse with a reg_rvalid pulse.
module hbi_ctrl
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              ale_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              cyc_active,
    input  logic              cyc_read,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_rvalid,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              ack_int
);

    hbi_state_t state_q;
    logic       is_rd_q;

    // Purpose: sequence a host cycle from detection through release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_rd_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (cyc_active) begin
                              is_rd_q <= cyc_read;
                              state_q <= ST_ISSUE;
                          end
                ST_ISSUE: state_q <= is_rd_q ? ST_WAIT : ST_ACK;
                ST_WAIT:  if (reg_rvalid) state_q <= ST_ACK;
                ST_ACK:   if (!cyc_active) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: hold the address (latch-enable follow in mode 0, cycle start in mode 1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (mode_sel == MODE_SPLIT) begin
            if (ale_s) addr_q <= addr_s;
        end else if (state_q == ST_IDLE && cyc_active) begin
            addr_q <= addr_s;
        end
    end

    // Purpose: capture write data once per cycle so later bus noise is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wdata_q <= '0;
        else if (state_q == ST_IDLE && cyc_active) wdata_q <= data_s;
    end

    // Purpose: hold returned read data for the host data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdata_q <= '0;
        else if (state_q == ST_WAIT && reg_rvalid) rdata_q <= reg_rdata;
    end

    assign reg_rd  = (state_q == ST_ISSUE) &&  is_rd_q;
    assign reg_wr  = (state_q == ST_ISSUE) && !is_rd_q;
    assign ack_int = (state_q == ST_ACK);

    // R5: never both internal strobes at once.
    assert_no_dual_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R5: every internal pulse lasts exactly one clock.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |=> !(reg_rd || reg_wr));

    // R8: a write is acknowledged right after it has been issued.
    assert_write_then_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ack_int);

    // R8: returned read data leads straight to the handshake.
    assert_read_then_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && reg_rvalid) |=> ack_int);

    // R8: the handshake is dropped once the host has released the strobes.
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_int && !cyc_active) |=> !ack_int);

    // R9: held write data does not move while the handshake is active.
    assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |=> $stable(wdata_q));

endmodule

// File: rtl/hbi_host_bridge.sv
// Top of the dual-convention host bus bridge.
// Synchronizes every host input, decodes the cycle per mode, runs the
// cycle controller, and applies the per-mode handshake polarity. The data
// bus enable follows the raw pins so that the bus is released as soon as
// the host lifts its read strobe.
// Assumes mode_sel is static and the host holds address and data stable
// while its strobes are asserted.
module hbi_host_bridge
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              strb_n,
    input  logic              rdwr,
    input  logic              ds_n,
    output logic              ack_out,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_rvalid
);

    localparam int CTL_W  = 4;
    localparam int SYNC_W = CTL_W + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{CTL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

    logic [SYNC_W-1:0] sync_d, sync_q;
    logic              ale_s, strb_n_s, rdwr_s, ds_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              cyc_active, cyc_read, ack_int;
    logic [DATA_W-1:0] rdata_q;

    assign sync_d = {ale, strb_n, rdwr, ds_n, addr_in, data_in};

    hbi_sync #(
        .W       (SYNC_W),
        .STAGES  (STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_d),
        .q     (sync_q)
    );

    assign {ale_s, strb_n_s, rdwr_s, ds_n_s, addr_s, data_s} = sync_q;

    hbi_decode u_decode (
        .mode_sel   (mode_sel),
        .strb_n_s   (strb_n_s),
        .rdwr_s     (rdwr_s),
        .ds_n_s     (ds_n_s),
        .cyc_active (cyc_active),
        .cyc_read   (cyc_read)
    );

    hbi_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .ale_s      (ale_s),
        .addr_s     (addr_s),
        .data_s     (data_s),
        .cyc_active (cyc_active),
        .cyc_read   (cyc_read),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .addr_q     (reg_addr),
        .wdata_q    (reg_wdata),
        .rdata_q    (rdata_q),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .ack_int    (ack_int)
    );

    // Purpose: drive the host data bus only during a selected read.
    always_comb begin
        if (mode_sel == MODE_STROBE) data_oe = !strb_n && rdwr;
        else                         data_oe = !strb_n && !rdwr;
    end

    assign data_out = rdata_q;

    // Purpose: apply the handshake polarity of the selected convention.
    assign ack_out = (mode_sel == MODE_STROBE) ? !ack_int : ack_int;

    // R6: the bus is never driven while the host is writing (mode 0).
    assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_SPLIT && !ds_n && rdwr) |-> !data_oe);

    // R5: no internal pulse while the synchronized bus is idle and no cycle is open.
    assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_active && !ack_int && !reg_rd && !reg_wr && $past(!cyc_active)) |=> !(reg_rd || reg_wr));

endmodule

// File: tb/hbi_host_bridge_test.sv
`timescale 1ns/1ps
module hbi_host_bridge_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_sel;
    logic       ale;
    logic [9:0] addr_in;
    logic [7:0] data_in;
    logic [7:0] data_out;
    logic       data_oe;
    logic       strb_n, rdwr, ds_n;
    logic       ack_out;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_rdata;
    logic       reg_rvalid;

    int tests = 0;
    int fails = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [9:0] last_wa, last_ra;
    logic [7:0] last_wd;

    always #4 clk = ~clk;

    hbi_host_bridge uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ale(ale),
        .addr_in(addr_in), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .strb_n(strb_n), .rdwr(rdwr), .ds_n(ds_n),
        .ack_out(ack_out), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid)
    );

    function automatic logic [7:0] rd_value(input logic [9:0] a);
        return a[7:0] ^ {6'b0, a[9:8]} ^ 8'hC3;
    endfunction

    // Register port model: one-clock read latency, records every access.
    always @(posedge clk) begin
        reg_rvalid <= 1'b0;
        if (rst_n) begin
            if (reg_wr) begin
                wr_cnt  <= wr_cnt + 1;
                last_wa <= reg_addr;
                last_wd <= reg_wdata;
            end
            if (reg_rd) begin
                rd_cnt     <= rd_cnt + 1;
                last_ra    <= reg_addr;
                reg_rvalid <= 1'b1;
                reg_rdata  <= rd_value(reg_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic ack_on();
        return mode_sel ? !ack_out : ack_out;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ack(input string req);
        int i;
        for (i = 0; i < 20 && !ack_on(); i++) @(negedge clk);
        chk(ack_on(), req, ack_out, mode_sel ? 0 : 1);
    endtask

    task automatic idle_pins();
        strb_n = 1'b1; rdwr = 1'b1; ds_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_sel = 1'b0; ale = 1'b1;
        addr_in = '0; data_in = '0; idle_pins();
        cyc(4);
        rst_n = 1'b1;
        cyc(3);
        chk(!reg_wr && !reg_rd, "R10 pulses", {reg_wr, reg_rd}, 0);
        chk(!data_oe, "R10 oe", data_oe, 0);
        chk(ack_out == 1'b0, "R10/R7 mode0 idle ack", ack_out, 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 no cycle when idle", wr_cnt + rd_cnt, 0);
    endtask

    task automatic t_m0_write(input logic [9:0] a, input logic [7:0] d);
        int w0 = wr_cnt;
        addr_in = a; ale = 1'b1; cyc(4);
        ale = 1'b0; cyc(1);
        addr_in = ~a;                 // R2: must not be used
        cyc(3);
        data_in = d; strb_n = 1'b0; ds_n = 1'b0;
        wait_ack("R8 mode0 write ack");
        chk(ack_out == 1'b1, "R7 mode0 ready high", ack_out, 1);
        data_in = ~d;                 // R9 disturbance
        cyc(6);
        chk(wr_cnt == w0 + 1, "R5 one write pulse", wr_cnt - w0, 1);
        chk(last_wa == a, "R2 latched address", last_wa, a);
        chk(last_wd == d, "R3 write data", last_wd, d);
        chk(reg_wdata == d, "R9 held write data", reg_wdata, d);
        chk(ack_on(), "R8 ack held", ack_out, 1);
        chk(!data_oe, "R6 no drive on write", data_oe, 0);
        idle_pins(); cyc(4);
        chk(!ack_on(), "R8 ack removed", ack_out, 0);
        ale = 1'b1;
    endtask

    task automatic t_m0_read(input logic [9:0] a);
        int r0 = rd_cnt;
        addr_in = a; ale = 1'b1; cyc(4);
        ale = 1'b0; cyc(1); addr_in = 10'h111; cyc(3);
        strb_n = 1'b0; rdwr = 1'b0;
        cyc(1);
        chk(data_oe, "R6 oe on mode0 read", data_oe, 1);
        wait_ack("R8 mode0 read ack");
        chk(data_out == rd_value(a), "R6 read data", data_out, rd_value(a));
        cyc(6);
        chk(rd_cnt == r0 + 1, "R5 one read pulse", rd_cnt - r0, 1);
        chk(last_ra == a, "R2 read address", last_ra, a);
        idle_pins(); cyc(1);
        chk(!data_oe, "R6 oe released", data_oe, 1'b0);
        cyc(3);
        chk(!ack_on(), "R8 read ack removed", ack_out, 0);
        ale = 1'b1;
    endtask

    task automatic t_m0_unselected();
        int n0 = wr_cnt + rd_cnt;
        strb_n = 1'b1; rdwr = 1'b0; cyc(8);
        chk(!data_oe, "R6 no drive unselected", data_oe, 0);
        rdwr = 1'b1; ds_n = 1'b0; cyc(8);
        chk(wr_cnt + rd_cnt == n0, "R3 no cycle without select", wr_cnt + rd_cnt - n0, 0);
        chk(!ack_on(), "R3 no ack without select", ack_out, 0);
        idle_pins(); cyc(4);
    endtask

    task automatic t_m1_write(input logic [9:0] a, input logic [7:0] d);
        int w0 = wr_cnt;
        mode_sel = 1'b1; ale = 1'b1; cyc(3);
        chk(ack_out == 1'b1, "R7 mode1 idle ack high", ack_out, 1);
        addr_in = a; data_in = d; rdwr = 1'b0; strb_n = 1'b0;
        cyc(8);
        chk(wr_cnt == w0, "R4 address strobe alone starts nothing", wr_cnt - w0, 0);
        ds_n = 1'b0;
        wait_ack("R8 mode1 write ack");
        chk(ack_out == 1'b0, "R7 mode1 ack low", ack_out, 0);
        data_in = 8'h00; cyc(5);
        chk(wr_cnt == w0 + 1, "R5 one mode1 write", wr_cnt - w0, 1);
        chk(last_wa == a && last_wd == d, "R4 mode1 addr/data", {last_wa, last_wd}, {a, d});
        chk(reg_wdata == d, "R9 mode1 held data", reg_wdata, d);
        idle_pins(); cyc(4);
        chk(ack_out == 1'b1, "R8 mode1 ack removed", ack_out, 1);
    endtask

    task automatic t_m1_read(input logic [9:0] a);
        int r0 = rd_cnt;
        addr_in = a; rdwr = 1'b1; strb_n = 1'b0; ds_n = 1'b0;
        cyc(1);
        chk(data_oe, "R6 oe on mode1 read", data_oe, 1);
        wait_ack("R8 mode1 read ack");
        chk(data_out == rd_value(a), "R4 mode1 read data", data_out, rd_value(a));
        cyc(4);
        chk(rd_cnt == r0 + 1 && last_ra == a, "R5 one mode1 read", rd_cnt - r0, 1);
        idle_pins(); cyc(1);
        chk(!data_oe, "R6 mode1 oe released", data_oe, 0);
        cyc(3);
        chk(ack_out == 1'b1, "R8 mode1 read ack removed", ack_out, 1);
    endtask

    task automatic t_back_to_back();
        int w0 = wr_cnt;
        for (int k = 0; k < 3; k++) begin
            addr_in = 10'h300 + 10'(k); data_in = 8'h10 + 8'(k);
            rdwr = 1'b0; strb_n = 1'b0; ds_n = 1'b0;
            wait_ack("R8 burst ack");
            idle_pins(); cyc(4);
        end
        chk(wr_cnt == w0 + 3, "R5 three cycles three pulses", wr_cnt - w0, 3);
        chk(last_wd == 8'h12, "R4 last burst data", last_wd, 8'h12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_m0_write(10'h2A5, 8'h3C);
        t_m0_read(10'h15A);
        t_m0_unselected();
        t_m0_write(10'h001, 8'hFF);
        t_m1_write(10'h3F0, 8'h96);
        t_m1_read(10'h0C7);
        t_back_to_back();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule